// File: doc/BRIEF.md
# Bus Master Latency-Timer Preemption Controller

This block decides when a bus master running a PCI-style burst has to give the bus back. When the master begins a transaction, a down-counter is loaded from a programmable latency value. The counter then drops by one on every bus clock until it reaches zero. The block compares the arbiter grant with the master's own request. When the grant has been withdrawn and the counter has also run out, it drives a master-initiated termination. It does this by releasing the frame strobe while keeping the initiator-ready strobe asserted, which marks the current phase as the final one.

While the counter is nonzero, a withdrawn grant does not end the burst. The master keeps ownership and goes on transferring until its guaranteed tenure is used up. A larger programmed value therefore makes the master slower to yield. The burst engine can also end a transfer on its own by dropping its burst-active request. Address decoding, target behaviour, arbitration and parity lie outside this block.

The controller is a four-state machine:
- `ST_IDLE`: both strobes are released.
- `ST_ADDR`: the frame strobe is asserted and initiator-ready is released.
- `ST_DATA`: both strobes are asserted.
- `ST_LAST`: the frame strobe is released and initiator-ready is asserted.

Its transitions are:
- START (`ST_IDLE`→`ST_ADDR`): burst-active is high, the request is low and the grant is low.
- ADVANCE (`ST_ADDR`→`ST_DATA`): taken unconditionally.
- PREEMPT_END (`ST_DATA`→`ST_LAST`): the master is preempted and the counter is zero.
- NORMAL_END (`ST_DATA`→`ST_LAST`): burst-active is low.
- FINISH (`ST_LAST`→`ST_IDLE`): TRDY# is low.

All other cases hold the current state.

Top module: `lt_preempt_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the next cycle shows frame_n=1, irdy_n=1, last_phase=0 and timeout=0, and the latency count is cleared.
- R2: From idle, a transaction starts only at an edge where burst_active=1, req_n=0 and gnt_n=0. The next cycle is an address cycle (frame_n=0, irdy_n=1), and every later cycle until the end has frame_n=0 and irdy_n=0. When gnt_n=1, the block stays idle.
- R3: At the START edge the count is loaded with lat_value. It then drops by one at every later edge, whether or not TRDY# is asserted, and holds at zero. With the grant withdrawn from the first cycle after START, frame_n stays low for exactly max(lat_value+1, 2) cycles.
- R4: A preemption (gnt_n=1 while req_n=0) that happens while the count is nonzero does not end the burst. frame_n stays 0, including when the grant comes back later.
- R5: In a data cycle with the count at zero and the master preempted, the next cycle has frame_n=1, irdy_n=0 and last_phase=1.
- R6: If the count reaches zero while gnt_n=0, the burst continues unchanged. A later withdrawal of the grant ends it at the next edge.
- R7: The final phase (frame_n=1, irdy_n=0, last_phase=1) holds while trdy_n=1. The cycle after an edge with trdy_n=0 shows frame_n=1, irdy_n=1 and last_phase=0.
- R8: timeout is high for exactly one cycle, the first final-phase cycle of a termination caused by preemption. This holds even if burst_active falls at the same edge.
- R9: Dropping burst_active in a data cycle moves the block to the final phase at the next edge, and timeout stays 0.
- R10: A withdrawn grant while req_n=1 is not a preemption and does not end the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lat_value | input | LAT_W | Programmed latency count |
| gnt_n | input | 1 | Arbiter grant, active low |
| req_n | input | 1 | Master's own bus request, active low |
| burst_active | input | 1 | Burst engine has data to move |
| trdy_n | input | 1 | Target ready, active low |
| frame_n | output | 1 | Frame strobe, active low |
| irdy_n | output | 1 | Initiator ready, active low |
| last_phase | output | 1 | The current data phase is the final one |
| timeout | output | 1 | One-cycle pulse on a preemption-forced termination |

## Verification
Two termination causes can meet at one edge: the expiry-plus-preemption end, and the burst engine dropping burst-active. The bench provokes this by withdrawing the grant and lowering burst-active together in the first data cycle where a latency value of one has already run out. It then expects the final phase on the next cycle with the timeout flag raised, because preemption takes priority for the flag. It also times the preemption end against several latency values, some runs with wait states and some without, and checks that a grant withdrawn while the count is nonzero, or while the request is idle, leaves the frame strobe asserted.

// File: rtl/lt_preempt_pkg.sv
package lt_preempt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_LAST = 2'd3
    } bus_state_t;

endpackage

// File: rtl/lt_latency_counter.sv
module lt_latency_counter #(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [LAT_W-1:0] load_val,
    output logic             cnt_zero
);

    localparam logic [LAT_W-1:0] ONE  = LAT_W'(1);
    localparam logic [LAT_W-1:0] ZERO = '0;

    logic [LAT_W-1:0] cnt_q;

    // Loaded on the frame-start edge, decremented every clock of a
    // transaction (wait states included), saturating at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= ZERO;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != ZERO)) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign cnt_zero = (cnt_q == ZERO);

endmodule

// File: rtl/lt_preempt_detect.sv
module lt_preempt_detect (
    input  logic gnt_n,
    input  logic req_n,
    input  logic cnt_zero,
    output logic preempted,
    output logic must_yield
);

    // Grant withdrawn while still requesting the bus.
    assign preempted  = gnt_n && !req_n;
    // Guaranteed tenure used up as well: the bus has to be released.
    assign must_yield = preempted && cnt_zero;

endmodule

// File: rtl/lt_burst_fsm.sv
module lt_burst_fsm
    import lt_preempt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gnt_n,
    input  logic req_n,
    input  logic burst_active,
    input  logic trdy_n,
    input  logic must_yield,
    output logic start,
    output logic in_txn,
    output logic frame_n,
    output logic irdy_n,
    output logic last_phase,
    output logic timeout
);

    bus_state_t state_q;
    bus_state_t state_d;
    logic       timeout_q;

    assign start  = (state_q == ST_IDLE) && burst_active && !req_n && !gnt_n;
    assign in_txn = (state_q != ST_IDLE);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_ADDR;                      // START
            ST_ADDR: state_d = ST_DATA;                                 // ADVANCE
            ST_DATA: if (must_yield || !burst_active) state_d = ST_LAST; // PREEMPT_END / NORMAL_END
            ST_LAST: if (!trdy_n) state_d = ST_IDLE;                    // FINISH
            default: state_d = ST_IDLE;
        endcase
    end

    // Preemption-forced termination pulse, aligned with the first final-phase cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timeout_q <= 1'b0;
        end else begin
            timeout_q <= (state_q == ST_DATA) && must_yield;
        end
    end

    // Output decode
    always_comb begin
        frame_n    = 1'b1;
        irdy_n     = 1'b1;
        last_phase = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                frame_n = 1'b1;
                irdy_n  = 1'b1;
            end
            ST_ADDR: begin
                frame_n = 1'b0;
                irdy_n  = 1'b1;
            end
            ST_DATA: begin
                frame_n = 1'b0;
                irdy_n  = 1'b0;
            end
            ST_LAST: begin
                frame_n    = 1'b1;
                irdy_n     = 1'b0;
                last_phase = 1'b1;
            end
            default: begin
                frame_n = 1'b1;
                irdy_n  = 1'b1;
            end
        endcase
    end

    assign timeout = timeout_q;

endmodule

// File: rtl/lt_preempt_ctrl.sv
module lt_preempt_ctrl #(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LAT_W-1:0] lat_value,
    input  logic             gnt_n,
    input  logic             req_n,
    input  logic             burst_active,
    input  logic             trdy_n,
    output logic             frame_n,
    output logic             irdy_n,
    output logic             last_phase,
    output logic             timeout
);

    logic start;
    logic in_txn;
    logic cnt_zero;
    logic preempted;
    logic must_yield;

    lt_latency_counter #(.LAT_W(LAT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .run      (in_txn),
        .load_val (lat_value),
        .cnt_zero (cnt_zero)
    );

    lt_preempt_detect u_detect (
        .gnt_n      (gnt_n),
        .req_n      (req_n),
        .cnt_zero   (cnt_zero),
        .preempted  (preempted),
        .must_yield (must_yield)
    );

    lt_burst_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .gnt_n        (gnt_n),
        .req_n        (req_n),
        .burst_active (burst_active),
        .trdy_n       (trdy_n),
        .must_yield   (must_yield),
        .start        (start),
        .in_txn       (in_txn),
        .frame_n      (frame_n),
        .irdy_n       (irdy_n),
        .last_phase   (last_phase),
        .timeout      (timeout)
    );

endmodule

// File: rtl/lt_preempt_chk.sv
module lt_preempt_chk (
    input logic clk,
    input logic rst_n,
    input logic gnt_n,
    input logic req_n,
    input logic burst_active,
    input logic trdy_n,
    input logic cnt_zero,
    input logic frame_n,
    input logic irdy_n,
    input logic last_phase,
    input logic timeout
);

    // R2: an address cycle is always followed by a data cycle
    p_addr_then_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_n && irdy_n) |=> (!frame_n && !irdy_n));

    // R4: nonzero count with burst still wanted keeps the frame asserted
    p_hold_while_counting_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_n && !irdy_n && !cnt_zero && burst_active) |=> !frame_n);

    // R5: expired count plus preemption ends the burst next cycle
    p_expired_preempt_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_n && !irdy_n && cnt_zero && gnt_n && !req_n) |=> (frame_n && !irdy_n && last_phase));

    // R6: with grant held and burst wanted, the frame stays asserted
    p_granted_continues_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_n && !irdy_n && !gnt_n && burst_active) |=> !frame_n);

    // R7: final phase waits for target ready
    p_last_waits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_n && !irdy_n && trdy_n) |=> (frame_n && !irdy_n));

    // R7: final phase releases initiator ready after completion
    p_last_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_n && !irdy_n && !trdy_n) |=> (frame_n && irdy_n && !last_phase));

    // R8: timeout only in a final-phase cycle
    p_timeout_in_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (frame_n && !irdy_n && last_phase));

    // R8: timeout lasts a single cycle
    p_timeout_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout);

    // R10: request idle means no preemption end while burst wanted
    p_no_req_no_preempt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_n && !irdy_n && req_n && burst_active) |=> !frame_n);

endmodule

bind lt_preempt_ctrl lt_preempt_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .gnt_n        (gnt_n),
    .req_n        (req_n),
    .burst_active (burst_active),
    .trdy_n       (trdy_n),
    .cnt_zero     (cnt_zero),
    .frame_n      (frame_n),
    .irdy_n       (irdy_n),
    .last_phase   (last_phase),
    .timeout      (timeout)
);

// File: tb/lt_preempt_ctrl_test.sv
`timescale 1ns/1ps
module lt_preempt_ctrl_test;

    localparam int LAT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LAT_W-1:0] lat_value = '0;
    logic             gnt_n = 1'b1;
    logic             req_n = 1'b1;
    logic             burst_active = 1'b0;
    logic             trdy_n = 1'b1;
    logic             frame_n;
    logic             irdy_n;
    logic             last_phase;
    logic             timeout;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    lt_preempt_ctrl #(.LAT_W(LAT_W)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .lat_value    (lat_value),
        .gnt_n        (gnt_n),
        .req_n        (req_n),
        .burst_active (burst_active),
        .trdy_n       (trdy_n),
        .frame_n      (frame_n),
        .irdy_n       (irdy_n),
        .last_phase   (last_phase),
        .timeout      (timeout)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog (all) actual=%0d cycles expected<20000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Compare {frame_n, irdy_n, last_phase, timeout}
    task automatic check_out(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {frame_n, irdy_n, last_phase, timeout};
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Complete the final phase and return to idle (R7)
    task automatic finish_last();
        trdy_n       = 1'b0;
        burst_active = 1'b0;
        gnt_n        = 1'b0;
        req_n        = 1'b0;
        step();
        check_out("R7 release after final phase", 4'b1100);
        trdy_n = 1'b1;
    endtask

    task automatic begin_txn(input int lat);
        lat_value    = LAT_W'(lat);
        gnt_n        = 1'b0;
        req_n        = 1'b0;
        burst_active = 1'b1;
        step();
        check_out("R2 address cycle", 4'b0100);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        burst_active = 1'b1;
        req_n = 1'b0;
        gnt_n = 1'b0;
        repeat (3) step();
        check_out("R1 reset state", 4'b1100);
        gnt_n = 1'b1;
        rst_n = 1'b1;
        repeat (3) step();
        check_out("R2 no start without grant", 4'b1100);
        burst_active = 1'b0;
        step();
    endtask

    // Grant withdrawn from the first cycle after start; time the frame
    task automatic t_preempt_timing(input int lat, input logic waits);
        int low;
        int expv;
        begin_txn(lat);
        gnt_n  = 1'b1;
        trdy_n = waits;
        low = 1;
        for (int i = 0; i < 300; i++) begin
            step();
            if (frame_n == 1'b0) low++;
            else break;
        end
        expv = (lat + 1 > 2) ? lat + 1 : 2;
        check_int($sformatf("R3 R4 frame-low cycles lat=%0d waits=%0b", lat, waits), low, expv);
        check_out("R5 R8 final phase with timeout", 4'b1011);
        trdy_n = 1'b1;
        step();
        check_out("R7 R8 final phase held, timeout cleared", 4'b1010);
        finish_last();
    endtask

    task automatic t_expired_granted();
        begin_txn(2);
        for (int i = 0; i < 7; i++) begin
            step();
            check_out("R6 burst continues with grant held", 4'b0000);
        end
        gnt_n = 1'b1;
        step();
        check_out("R6 later grant loss ends burst", 4'b1011);
        finish_last();
    endtask

    task automatic t_normal_end();
        begin_txn(10);
        step();
        check_out("R2 data cycle", 4'b0000);
        burst_active = 1'b0;
        step();
        check_out("R9 normal end without timeout", 4'b1010);
        finish_last();
    endtask

    task automatic t_same_cycle();
        begin_txn(1);
        step();
        check_out("R2 data cycle before collision", 4'b0000);
        gnt_n = 1'b1;
        burst_active = 1'b0;
        step();
        check_out("R8 R9 simultaneous end flags timeout", 4'b1011);
        finish_last();
    endtask

    task automatic t_grant_returns();
        begin_txn(5);
        gnt_n = 1'b1;
        step();
        step();
        gnt_n = 1'b0;
        for (int i = 0; i < 6; i++) begin
            step();
            check_out("R4 brief preemption does not end burst", 4'b0000);
        end
        burst_active = 1'b0;
        step();
        check_out("R9 end after returned grant", 4'b1010);
        finish_last();
    endtask

    task automatic t_no_request();
        begin_txn(0);
        step();
        gnt_n = 1'b1;
        req_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            check_out("R10 grant loss without request ignored", 4'b0000);
        end
        req_n = 1'b0;
        step();
        check_out("R10 R5 preemption once requesting", 4'b1011);
        finish_last();
    endtask

    initial begin
        t_reset();
        t_preempt_timing(3, 1'b1);
        t_preempt_timing(3, 1'b0);
        t_preempt_timing(0, 1'b1);
        t_preempt_timing(1, 1'b0);
        t_preempt_timing(6, 1'b1);
        t_expired_granted();
        t_normal_end();
        t_same_cycle();
        t_grant_returns();
        t_no_request();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule